// File: doc/BRIEF.md
# Vector Mask Prefix-Count Unit

This block carries out the prefix-count ("iota") step of a vector unit. When a start pulse arrives, it checks the instruction word. It then takes a copy of the source mask register and the governing mask register. After that it walks the destination elements one per cycle. Each active element below the vector length receives the number of set source-mask bits at lower active positions. Elements that the governing mask switches off are not written. Elements from the vector length up to the maximum element count are written as zero.

The element width (8, 16, 32 or 64 bits) and the spacing of mask bits inside a mask register both come from the request. The spacing is given as the base-2 log of the mask-element length. Results leave through a single element write port, so the register file that owns the destination keeps the old value of every element that is skipped. A single-cycle done pulse closes every accepted request. If the request is illegal or has zero length, the pulse comes at once and nothing is written.

Top module: `vmask_iota_unit`

## Requirements
- R1: The instruction word is accepted only when it holds 010110 in bits [31:26], 10000 in bits [19:15], 010 in bits [14:12] and 1010111 in bits [6:0]. Any other word is flagged illegal.
- R2: A request is also illegal in three other cases. The first is when bit 25 (mask enable, 0 = masked) is 0 and the destination field, bits [11:7], is 0. The second is when the source field, bits [24:20], lies inside the destination group [vd, vd + 2^lmul_i). The third is when mlen_lg_i exceeds log2(VLEN). The flag is set at start. An illegal request makes no write and gives done in the cycle after start.
- R3: The maximum element count is VLEN >> mlen_lg_i. The mask bit for element i sits at bit i << mlen_lg_i of a mask image, and no other bit is examined. A vector length above the maximum count is clamped to it.
- R4: An accepted request with a nonzero length writes or skips one element per cycle. The indices run 0, 1, 2, … up to (max count − 1), starting in the cycle after start.
- R5: An active element i below the vector length receives the count of set source bits at active indices below i. Its own source bit is not included.
- R6: When bit 25 is 0 and the governing-mask bit of element i is clear, element i is not written and adds nothing to the count. When bit 25 is 1, the governing mask is ignored.
- R7: Every element from the vector length up to (max count − 1) is written with zero, whatever the masks hold.
- R8: The write data is the count reduced modulo 2^SEW, zero above bit SEW−1. Here sew_i is 0/1/2/3 for SEW 8/16/32/64, and wr_sew_o repeats the width captured at start.
- R9: A zero vector length gives no write at all, tail included, and done in the cycle after start.
- R10: done_o is high for the one cycle after the last element. busy_o is high from the cycle after start until then, and never at the same time as done_o.
- R11: A start pulse while busy is ignored. The running request keeps the operands and masks it captured.
- R12: After reset, wr_en_o, done_o, illegal_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse |
| insn_i | input | 32 | Instruction word |
| lmul_i | input | 2 | log2 of destination group size |
| sew_i | input | 2 | Element width code |
| mlen_lg_i | input | MLW | log2 of mask-element length |
| vl_i | input | VLW | Vector length |
| gov_mask_i | input | VLEN | Governing mask register image |
| src_mask_i | input | VLEN | Source mask register image |
| wr_en_o | output | 1 | Element write strobe |
| wr_idx_o | output | IW | Element index of the write |
| wr_data_o | output | 64 | Element value, zero above SEW |
| wr_sew_o | output | 2 | Width code of the write |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Last request was illegal |
| busy_o | output | 1 | Walk in progress |

## Verification
A new start pulse can arrive in the same cycle that the walk is writing an element. That collision checks whether the intake path and the sequencer stay apart. The bench raises start two cycles into a long walk. With that pulse it presents a different width and inverted masks. It then requires the whole destination image, every write's width code and the done latency to match a single clean run. Tail clearing and the count's wrap at the element width also meet in one walk. A 300-element run at 8-bit width is judged on the elements at indices 255, 256 and 299.

// File: rtl/iota_pkg.sv
`timescale 1ns/1ps
package iota_pkg;

  localparam logic [5:0] IOTA_FUNCT6 = 6'b010110;
  localparam logic [4:0] IOTA_SEL    = 5'b10000;
  localparam logic [2:0] IOTA_FUNCT3 = 3'b010;
  localparam logic [6:0] IOTA_OPC    = 7'b1010111;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} iota_state_e;

  // Reduce a value to the element width chosen by the width code.
  function automatic logic [63:0] sew_trunc(input logic [63:0] d, input logic [1:0] sew);
    logic [63:0] r;
    case (sew)
      2'd0:    r = {56'd0, d[7:0]};
      2'd1:    r = {48'd0, d[15:0]};
      2'd2:    r = {32'd0, d[31:0]};
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/iota_decode.sv
`timescale 1ns/1ps
module iota_decode import iota_pkg::*; #(
  parameter int VLEN = 128,
  parameter int MLW  = 3
) (
  input  logic [31:0]    insn_i,
  input  logic [1:0]     lmul_i,
  input  logic [MLW-1:0] mlg_i,
  output logic           vm_o,
  output logic           illegal_o
);
  localparam int LOGV = $clog2(VLEN);

  logic [4:0] vd, vs2;
  logic [5:0] grp_end;
  logic       enc_ok, v0_clash, overlap, mlg_bad;

  always_comb begin
    vd       = insn_i[11:7];
    vs2      = insn_i[24:20];
    vm_o     = insn_i[25];
    enc_ok   = (insn_i[31:26] == IOTA_FUNCT6) && (insn_i[19:15] == IOTA_SEL) &&
               (insn_i[14:12] == IOTA_FUNCT3) && (insn_i[6:0] == IOTA_OPC);
    v0_clash = !vm_o && (vd == 5'd0);
    grp_end  = {1'b0, vd} + (6'd1 << lmul_i);
    overlap  = (vs2 >= vd) && ({1'b0, vs2} < grp_end);
    mlg_bad  = int'(mlg_i) > LOGV;
    illegal_o = !enc_ok || v0_clash || overlap || mlg_bad;
  end

endmodule

// File: rtl/iota_mask_pick.sv
`timescale 1ns/1ps
module iota_mask_pick #(
  parameter int VLEN = 128,
  parameter int MLW  = 3,
  parameter int IW   = 7
) (
  input  logic [VLEN-1:0] mask_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [MLW-1:0]  mlg_i,
  output logic            bit_o
);
  logic [IW-1:0] pos;

  always_comb begin
    pos   = idx_i << mlg_i;
    bit_o = mask_i[pos];
  end

endmodule

// File: rtl/iota_seq.sv
`timescale 1ns/1ps
module iota_seq import iota_pkg::*; #(
  parameter int VLEN = 128,
  parameter int MLW  = 3,
  parameter int IW   = 7,
  parameter int VLW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            illegal_i,
  input  logic            vm_i,
  input  logic [1:0]      sew_i,
  input  logic [MLW-1:0]  mlg_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [VLEN-1:0] gov_i,
  input  logic [VLEN-1:0] src_i,
  output logic            wr_en_o,
  output logic [IW-1:0]   wr_idx_o,
  output logic [63:0]     wr_data_o,
  output logic [1:0]      wr_sew_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic            busy_o
);

  iota_state_e     st_q, st_d;
  logic [IW-1:0]   idx_q, idx_d, last_q, last_cap;
  logic [VLW-1:0]  cnt_q, cnt_d, vl_q;
  logic [MLW-1:0]  mlg_q;
  logic [1:0]      sew_q;
  logic            vm_q;
  logic [VLEN-1:0] gov_q, src_q;
  logic            done_q, done_d, ill_q, ill_d;
  logic            accept, cap_en, in_body, active, is_last;
  logic [VLW-1:0]  vlmax_w, vl_eff;
  logic [1:0]      pick_bits;
  logic [VLEN-1:0] pick_mask [2];

  assign pick_mask[0] = gov_q;
  assign pick_mask[1] = src_q;

  // One bit selector per captured mask image.
  generate
    for (genvar g = 0; g < 2; g++) begin : g_pick
      iota_mask_pick #(.VLEN(VLEN), .MLW(MLW), .IW(IW)) u_pick (
        .mask_i (pick_mask[g]),
        .idx_i  (idx_q),
        .mlg_i  (mlg_q),
        .bit_o  (pick_bits[g])
      );
    end
  endgenerate

  always_comb begin
    vlmax_w  = VLW'(VLEN) >> mlg_i;
    vl_eff   = (vl_i > vlmax_w) ? vlmax_w : vl_i;
    last_cap = IW'(vlmax_w - 1'b1);
    accept   = start_i && (st_q == ST_IDLE);
    cap_en   = accept && !illegal_i && (vl_eff != '0);
    in_body  = {1'b0, idx_q} < vl_q;
    active   = vm_q || pick_bits[0];
    is_last  = (idx_q == last_q);
  end

  always_comb begin
    busy_o    = (st_q == ST_RUN);
    wr_en_o   = busy_o && (!in_body || active);
    wr_idx_o  = idx_q;
    wr_data_o = in_body ? sew_trunc(64'(cnt_q), sew_q) : '0;
    wr_sew_o  = sew_q;
    done_o    = done_q;
    illegal_o = ill_q;
  end

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    ill_d  = ill_q;
    if (accept) begin
      ill_d = illegal_i;
      if (cap_en) begin
        st_d  = ST_RUN;
        idx_d = '0;
        cnt_d = '0;
      end else begin
        done_d = 1'b1;
      end
    end else if (st_q == ST_RUN) begin
      idx_d = idx_q + 1'b1;
      if (in_body && active && pick_bits[1]) cnt_d = cnt_q + 1'b1;
      if (is_last) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      ill_q  <= ill_d;
    end
  end

  // Operand capture, enabled only by an accepted legal request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q   <= '0;
      last_q <= '0;
      mlg_q  <= '0;
      sew_q  <= '0;
      vm_q   <= 1'b0;
      gov_q  <= '0;
      src_q  <= '0;
    end else if (cap_en) begin
      vl_q   <= vl_eff;
      last_q <= last_cap;
      mlg_q  <= mlg_i;
      sew_q  <= sew_i;
      vm_q   <= vm_i;
      gov_q  <= gov_i;
      src_q  <= src_i;
    end
  end

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |-> !wr_en_o);                                                 // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !is_last) |=> (busy_o && (idx_q == $past(idx_q) + 1'b1))); // R4
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && in_body && !active) |=> (cnt_q == $past(cnt_q)));         // R6
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !in_body) |-> (wr_data_o == '0));                        // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);                                                 // R10
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ((sew_q == $past(sew_q)) && (vm_q == $past(vm_q)))); // R11

endmodule

// File: rtl/vmask_iota_unit.sv
`timescale 1ns/1ps
module vmask_iota_unit #(
  parameter  int VLEN = 128,
  localparam int LOGV = $clog2(VLEN),
  localparam int IW   = LOGV,
  localparam int VLW  = LOGV + 1,
  localparam int MLW  = $clog2(LOGV + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [31:0]     insn_i,
  input  logic [1:0]      lmul_i,
  input  logic [1:0]      sew_i,
  input  logic [MLW-1:0]  mlen_lg_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [VLEN-1:0] gov_mask_i,
  input  logic [VLEN-1:0] src_mask_i,
  output logic            wr_en_o,
  output logic [IW-1:0]   wr_idx_o,
  output logic [63:0]     wr_data_o,
  output logic [1:0]      wr_sew_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic            busy_o
);

  logic dec_vm, dec_illegal;

  iota_decode #(.VLEN(VLEN), .MLW(MLW)) u_decode (
    .insn_i    (insn_i),
    .lmul_i    (lmul_i),
    .mlg_i     (mlen_lg_i),
    .vm_o      (dec_vm),
    .illegal_o (dec_illegal)
  );

  iota_seq #(.VLEN(VLEN), .MLW(MLW), .IW(IW), .VLW(VLW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .illegal_i (dec_illegal),
    .vm_i      (dec_vm),
    .sew_i     (sew_i),
    .mlg_i     (mlen_lg_i),
    .vl_i      (vl_i),
    .gov_i     (gov_mask_i),
    .src_i     (src_mask_i),
    .wr_en_o   (wr_en_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o),
    .wr_sew_o  (wr_sew_o),
    .done_o    (done_o),
    .illegal_o (illegal_o),
    .busy_o    (busy_o)
  );

endmodule

// File: tb/vmask_iota_unit_tb.sv
`timescale 1ns/1ps
module vmask_iota_unit_tb;
  localparam int VLEN = 512;
  localparam int LOGV = $clog2(VLEN);
  localparam int IW   = LOGV;
  localparam int VLW  = LOGV + 1;
  localparam int MLW  = $clog2(LOGV + 1);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [31:0]     insn;
  logic [1:0]      lmul, sew;
  logic [MLW-1:0]  mlg;
  logic [VLW-1:0]  vl;
  logic [VLEN-1:0] gov, src;
  logic            wr_en, done, illegal, busy;
  logic [IW-1:0]   wr_idx;
  logic [63:0]     wr_data;
  logic [1:0]      wr_sew;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] img     [VLEN];
  logic [63:0] exp_img [VLEN];

  always #2 clk = ~clk;

  vmask_iota_unit #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .insn_i(insn), .lmul_i(lmul),
    .sew_i(sew), .mlen_lg_i(mlg), .vl_i(vl), .gov_mask_i(gov), .src_mask_i(src),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .wr_sew_o(wr_sew),
    .done_o(done), .illegal_o(illegal), .busy_o(busy)
  );

  typedef struct packed {
    logic [1:0]  sew;
    logic [1:0]  lmul;
    logic [3:0]  mlg;
    logic        vm;
    logic [4:0]  vd;
    logic [4:0]  vs2;
    logic [9:0]  vl;
    logic [31:0] s_gov;
    logic [31:0] s_src;
    logic        ill;
  } tv_t;

  localparam int NV = 10;
  localparam tv_t TV [NV] = '{
    '{2'd0, 2'd0, 4'd3, 1'b1, 5'd4,  5'd8, 10'd40,  32'h1234_5678, 32'h6B3D_91C5, 1'b0},
    '{2'd1, 2'd1, 4'd4, 1'b0, 5'd2,  5'd1, 10'd20,  32'hA5F0_3C96, 32'hFFFF_0F0F, 1'b0},
    '{2'd2, 2'd2, 4'd5, 1'b0, 5'd8,  5'd0, 10'd16,  32'h0F0F_F0F0, 32'h3333_CCCC, 1'b0},
    '{2'd3, 2'd3, 4'd6, 1'b0, 5'd16, 5'd3, 10'd3,   32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0},
    '{2'd0, 2'd0, 4'd3, 1'b0, 5'd0,  5'd5, 10'd10,  32'hFFFF_FFFF, 32'h1111_1111, 1'b1},
    '{2'd0, 2'd2, 4'd3, 1'b1, 5'd4,  5'd6, 10'd10,  32'h0,         32'h1111_1111, 1'b1},
    '{2'd1, 2'd0, 4'd2, 1'b1, 5'd2,  5'd9, 10'd0,   32'h0,         32'hFFFF_FFFF, 1'b0},
    '{2'd0, 2'd0, 4'd7, 1'b0, 5'd4,  5'd2, 10'd100, 32'h9C4E_21B7, 32'h5D3A_E1F9, 1'b0},
    '{2'd0, 2'd0, 4'd10,1'b1, 5'd4,  5'd2, 10'd5,   32'h0,         32'hFFFF_FFFF, 1'b1},
    '{2'd1, 2'd1, 4'd8, 1'b0, 5'd4,  5'd6, 10'd1,   32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0}
  };

  function automatic logic [31:0] mk_insn(input logic vm_b, input logic [4:0] vs2_f,
                                          input logic [4:0] vd_f, input logic [4:0] sel);
    return {6'b010110, vm_b, vs2_f, sel, 3'b010, vd_f, 7'b1010111};
  endfunction

  function automatic logic [VLEN-1:0] expand(input logic [31:0] seed);
    logic [VLEN-1:0] m;
    for (int k = 0; k < VLEN / 32; k++) m[k*32 +: 32] = seed ^ (32'(k) * 32'h9E37_79B9);
    return m;
  endfunction

  function automatic logic [63:0] wmask(input logic [1:0] s);
    case (s)
      2'd0:    return 64'hFF;
      2'd1:    return 64'hFFFF;
      2'd2:    return 64'hFFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_case(input logic [31:0] w, input logic [1:0] s, input logic [1:0] lm,
                          input int mg, input int vlen_req, input logic [VLEN-1:0] g,
                          input logic [VLEN-1:0] sm, input bit exp_ill, input bit inject,
                          input string tag);
    int vlmax, vle, lat, k, cnt, nwr, bad_i;
    bit idx_err, sew_err, hi_err, busy_err, done_seen, vm_b;
    vm_b  = w[25];
    vlmax = (mg <= LOGV) ? (VLEN >> mg) : 0;
    vle   = (vlen_req > vlmax) ? vlmax : vlen_req;
    for (int i = 0; i < VLEN; i++) begin
      img[i]     = {32'hC0DE_0000 | 32'(i), 32'h5A5A_0000 ^ 32'(i)};
      exp_img[i] = img[i];
    end
    cnt = 0;
    if (!exp_ill && vle > 0) begin
      for (int i = 0; i < vlmax; i++) begin
        if (i >= vle) exp_img[i] = '0;
        else if (vm_b || g[i << mg]) begin
          exp_img[i] = 64'(cnt) & wmask(s);
          if (sm[i << mg]) cnt++;
        end
      end
    end
    lat = (!exp_ill && vle > 0) ? vlmax : 0;

    insn = w; sew = s; lmul = lm; mlg = MLW'(mg); vl = VLW'(vlen_req);
    gov = g; src = sm; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0; nwr = 0; done_seen = 0;
    idx_err = 0; sew_err = 0; hi_err = 0; busy_err = 0;
    while (!done_seen && k < 1200) begin
      if (k < lat && !busy) busy_err = 1;
      if (wr_en) begin
        nwr++;
        if (int'(wr_idx) != k) idx_err = 1;
        if (wr_sew != s) sew_err = 1;
        if ((wr_data & ~wmask(s)) != '0) hi_err = 1;
        img[wr_idx] = wr_data;
      end
      if (done) done_seen = 1;
      else begin
        if (inject && k == 2) begin
          start = 1'b1; sew = s ^ 2'd1; gov = ~g; src = ~sm; insn = mk_insn(1'b1, 5'd1, 5'd8, 5'b10000);
        end
        if (inject && k == 3) start = 1'b0;
        @(negedge clk);
        k++;
      end
    end
    start = 1'b0;
    chk(done_seen && k == lat, {tag, " R4/R9/R10 done latency"}, k, lat);
    chk(illegal == exp_ill, {tag, " R1/R2 illegal flag"}, illegal, exp_ill);
    chk(!idx_err, {tag, " R4 write index order"}, idx_err, 0);
    chk(!sew_err && !hi_err, {tag, " R8 width code and upper bits"}, {sew_err, hi_err}, 0);
    chk(!busy_err, {tag, " R10 busy during walk"}, busy_err, 0);
    if (exp_ill || vle == 0) chk(nwr == 0, {tag, " R2/R9 no writes"}, nwr, 0);
    bad_i = -1;
    for (int i = 0; i < VLEN; i++) if (bad_i < 0 && img[i] != exp_img[i]) bad_i = i;
    if (bad_i < 0) chk(1'b1, "", 0, 0);
    else chk(1'b0, {tag, $sformatf(" R3/R5/R6/R7 element %0d", bad_i)},
             longint'(img[bad_i]), longint'(exp_img[bad_i]));
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tv_t t;
    rst_n = 1'b0; start = 1'b0; insn = '0; lmul = '0; sew = '0; mlg = '0; vl = '0;
    gov = '0; src = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(!wr_en && !done && !illegal && !busy, "R12 reset outputs",
        {wr_en, done, illegal, busy}, 0);

    for (int n = 0; n < NV; n++) begin
      t = TV[n];
      run_case(mk_insn(t.vm, t.vs2, t.vd, 5'b10000), t.sew, t.lmul, int'(t.mlg), int'(t.vl),
               expand(t.s_gov), expand(t.s_src), t.ill, 1'b0, $sformatf("vec%0d", n));
    end

    // R1: wrong selector field is rejected
    run_case(mk_insn(1'b1, 5'd1, 5'd8, 5'b00001), 2'd0, 2'd0, 3, 10, '0, '1, 1'b1, 1'b0, "bad_enc");

    // R8: count wraps at 8-bit width, tail still zero
    run_case(mk_insn(1'b1, 5'd1, 5'd8, 5'b10000), 2'd0, 2'd0, 0, 300, '0, '1, 1'b0, 1'b0, "wrap8");
    chk(img[255] == 64'd255 && img[256] == 64'd0 && img[299] == 64'd43,
        "R8 wrap at 256", longint'(img[299]), 43);
    chk(img[300] == 64'd0 && img[511] == 64'd0, "R7 long tail zero", longint'(img[300]), 0);

    // R8: same walk at 16-bit width keeps the full count
    run_case(mk_insn(1'b1, 5'd1, 5'd8, 5'b10000), 2'd1, 2'd0, 0, 300, '0, '1, 1'b0, 1'b0, "full16");
    chk(img[299] == 64'd299, "R8 16-bit count", longint'(img[299]), 299);

    // R11: start during a running walk is ignored
    run_case(mk_insn(1'b0, 5'd8, 5'd4, 5'b10000), 2'd1, 2'd0, 2, 90, expand(32'h7E1D_4A2B),
             expand(32'h2C9F_B316), 1'b0, 1'b1, "R11 inject");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule